// File: doc/BRIEF.md
# SDRAM Command Front End with Bank Tracking

This block is the device-side front end of a four-bank synchronous DRAM. On every rising clock edge it samples the clock enable, the active-low chip select, the three active-low command strobes (row, column, write), a 12-bit address and a 2-bit bank number. From these it decodes at most one command per cycle. It keeps an open or closed flag and a latched row for every bank. It reports each accepted command as a one-cycle pulse, together with the column address, the target bank and an auto-precharge request.

Address bit 10 means different things for different commands. On a read or write it schedules an automatic close of the addressed bank once a burst of `BURST_LEN` cycles has run. On a precharge it widens the close from the named bank to every bank.

A command that breaks the bank rules raises an error pulse in place of its command pulse, and it leaves all state unchanged. The rules are: a read or write to a closed bank, an activate to an open bank, and a refresh while any bank is open. A pending automatic close is a running operation, so it keeps counting while chip select is high, and it stops only while the clock enable is low.

Top module: `sdram_cmd_front`

## Requirements
- R1: After reset every bank is closed, every latched row and the mode word are zero, and all pulses, the column and the bank output are zero.
- R2: An activate (strobes row/column/write = 0,1,1) to a closed bank pulses act_o in the cycle after the sampling edge, opens that bank and latches all 12 address bits as its row.
- R3: A read (1,0,1) or write (1,0,0) to an open bank pulses rd_o or wr_o one cycle later, and it presents address bits 7:0 on col_o and the bank number on cmd_bank_o. Both outputs hold until the next accepted read or write.
- R4: A read or write accepted with address bit 10 high also pulses autopre_o, and it closes the addressed bank at the BURST_LEN-th clock-enabled edge after the command. With bit 10 low the bank stays open.
- R5: A precharge (0,1,0) pulses pre_o and closes every bank when address bit 10 is high, or only the bank on ba_i when bit 10 is low. It leaves latched rows untouched.
- R6: With chip select high no command is decoded and no pulse appears, but pending automatic closes keep counting.
- R7: With clock enable sampled low nothing is decoded and all bank state, including pending automatic closes, holds.
- R8: A read or write to a closed bank, or an activate to an open bank, pulses err_o instead of its command pulse and changes no bank state, column or bank output.
- R9: A refresh (0,0,1) pulses ref_o only when all banks are closed; otherwise it pulses err_o.
- R10: A mode load (0,0,0) pulses mrs_o and latches all 12 address bits on mode_o.
- R11: Strobe codes 1,1,1 and 1,1,0 have no effect, and at most one of the command and error pulses is high in any cycle.
- R12: A command sampled on the edge where an automatic close completes sees the bank still open. An activate there is an error. A read or write with bit 10 high there restarts the count, and the bank stays open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, all inputs sampled on the rising edge |
| rst_ni | input | 1 | Active-low synchronous reset |
| cke_i | input | 1 | Clock enable, low freezes the block |
| cs_ni | input | 1 | Active-low chip select |
| ras_ni | input | 1 | Active-low row strobe |
| cas_ni | input | 1 | Active-low column strobe |
| we_ni | input | 1 | Active-low write enable |
| addr_i | input | 12 | Row, column, mode word or bit-10 qualifier |
| ba_i | input | 2 | Bank number |
| act_o | output | 1 | Activate accepted |
| rd_o | output | 1 | Read accepted |
| wr_o | output | 1 | Write accepted |
| pre_o | output | 1 | Precharge accepted |
| ref_o | output | 1 | Refresh accepted |
| mrs_o | output | 1 | Mode load accepted |
| autopre_o | output | 1 | Accepted read or write requests automatic close |
| err_o | output | 1 | Command rejected by the bank rules |
| cmd_bank_o | output | 2 | Bank of the last accepted read or write |
| col_o | output | 8 | Column of the last accepted read or write |
| bank_open_o | output | 4 | Per-bank open flag |
| bank_row_o | output | 48 | Latched rows, bank n in bits 12n+11:12n |
| mode_o | output | 12 | Last mode word |

## Verification
Two functions can act on the same bank at the same edge: a pending automatic close reaching its end, and a newly decoded command to that bank. The bench provokes this by issuing an auto-precharge read, letting exactly BURST_LEN-1 idle cycles pass, and then sending either an activate or another auto-precharge write to the same bank on the expiry edge. The reference model applies the rule that decode sees the pre-edge state, and a new load outranks the expiry. The bench compares the error pulse, the open flags and the later close timing cycle by cycle against that model.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

   typedef enum logic [2:0] {
      CMD_NONE,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF,
      CMD_MRS
   } cmd_e;

   // strobe order: row, column, write (all active low)
   function automatic cmd_e strobe_to_cmd(input logic [2:0] rcw);
      cmd_e c;
      case (rcw)
         3'b011:  c = CMD_ACT;
         3'b101:  c = CMD_RD;
         3'b100:  c = CMD_WR;
         3'b010:  c = CMD_PRE;
         3'b001:  c = CMD_REF;
         3'b000:  c = CMD_MRS;
         default: c = CMD_NONE;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
   import sdram_cmd_pkg::*;
(
   input  logic cke_i,
   input  logic cs_ni,
   input  logic ras_ni,
   input  logic cas_ni,
   input  logic we_ni,
   output cmd_e cmd_o
);

   always_comb begin
      if (cke_i && !cs_ni) cmd_o = strobe_to_cmd({ras_ni, cas_ni, we_ni});
      else                 cmd_o = CMD_NONE;
   end

endmodule

// File: rtl/sdram_bank_slot.sv
module sdram_bank_slot #(
   parameter int ROW_W     = 12,
   parameter int BURST_LEN = 4
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             en_i,
   input  logic             act_i,
   input  logic [ROW_W-1:0] row_i,
   input  logic             pre_i,
   input  logic             ap_i,
   output logic             open_o,
   output logic [ROW_W-1:0] row_o
);

   localparam int CNT_W = $clog2(BURST_LEN + 1);

   logic [CNT_W-1:0] ap_cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         open_o   <= 1'b0;
         row_o    <= '0;
         ap_cnt_q <= '0;
      end else if (en_i) begin
         if (act_i) begin
            open_o   <= 1'b1;
            row_o    <= row_i;
            ap_cnt_q <= '0;
         end else if (pre_i) begin
            open_o   <= 1'b0;
            ap_cnt_q <= '0;
         end else if (ap_i) begin
            ap_cnt_q <= CNT_W'(BURST_LEN);
         end else if (ap_cnt_q != '0) begin
            ap_cnt_q <= ap_cnt_q - 1'b1;
            if (ap_cnt_q == CNT_W'(1)) open_o <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/sdram_cmd_front.sv
module sdram_cmd_front
   import sdram_cmd_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int BANK_W    = 2,
   parameter int COL_W     = 8,
   parameter int AP_BIT    = 10,
   parameter int BURST_LEN = 4
) (
   input  logic                              clk_i,
   input  logic                              rst_ni,
   input  logic                              cke_i,
   input  logic                              cs_ni,
   input  logic                              ras_ni,
   input  logic                              cas_ni,
   input  logic                              we_ni,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic [BANK_W-1:0]                 ba_i,
   output logic                              act_o,
   output logic                              rd_o,
   output logic                              wr_o,
   output logic                              pre_o,
   output logic                              ref_o,
   output logic                              mrs_o,
   output logic                              autopre_o,
   output logic                              err_o,
   output logic [BANK_W-1:0]                 cmd_bank_o,
   output logic [COL_W-1:0]                  col_o,
   output logic [(1<<BANK_W)-1:0]            bank_open_o,
   output logic [(1<<BANK_W)*ADDR_W-1:0]     bank_row_o,
   output logic [ADDR_W-1:0]                 mode_o
);

   localparam int NB = 1 << BANK_W;

   if (AP_BIT >= ADDR_W) begin : g_bad_ap
      $error("AP_BIT must lie inside the address");
   end
   if (COL_W > AP_BIT) begin : g_bad_col
      $error("column field must sit below AP_BIT");
   end
   if (BURST_LEN < 1) begin : g_bad_bl
      $error("BURST_LEN must be at least 1");
   end
   if (BANK_W < 1) begin : g_bad_bw
      $error("BANK_W must be at least 1");
   end

   cmd_e            cmd;
   logic [NB-1:0]   open_vec;
   logic [NB-1:0]   bank_hit;
   logic            tgt_open, ap_flag, is_rw;
   logic            legal_act, legal_rw, legal_ref, bad_cmd;

   sdram_cmd_decode u_dec (
      .cke_i  (cke_i),
      .cs_ni  (cs_ni),
      .ras_ni (ras_ni),
      .cas_ni (cas_ni),
      .we_ni  (we_ni),
      .cmd_o  (cmd)
   );

   assign bank_hit  = NB'(1) << ba_i;
   assign tgt_open  = |(open_vec & bank_hit);
   assign ap_flag   = addr_i[AP_BIT];
   assign is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign legal_act = (cmd == CMD_ACT) && !tgt_open;
   assign legal_rw  = is_rw && tgt_open;
   assign legal_ref = (cmd == CMD_REF) && (open_vec == '0);
   assign bad_cmd   = ((cmd == CMD_ACT) && tgt_open) ||
                      (is_rw && !tgt_open) ||
                      ((cmd == CMD_REF) && (open_vec != '0));

   for (genvar b = 0; b < NB; b++) begin : g_bank
      sdram_bank_slot #(
         .ROW_W     (ADDR_W),
         .BURST_LEN (BURST_LEN)
      ) u_slot (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .en_i   (cke_i),
         .act_i  (legal_act && bank_hit[b]),
         .row_i  (addr_i),
         .pre_i  ((cmd == CMD_PRE) && (ap_flag || bank_hit[b])),
         .ap_i   (legal_rw && ap_flag && bank_hit[b]),
         .open_o (open_vec[b]),
         .row_o  (bank_row_o[b*ADDR_W +: ADDR_W])
      );
   end

   assign bank_open_o = open_vec;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         act_o      <= 1'b0;
         rd_o       <= 1'b0;
         wr_o       <= 1'b0;
         pre_o      <= 1'b0;
         ref_o      <= 1'b0;
         mrs_o      <= 1'b0;
         autopre_o  <= 1'b0;
         err_o      <= 1'b0;
         cmd_bank_o <= '0;
         col_o      <= '0;
         mode_o     <= '0;
      end else begin
         act_o     <= legal_act;
         rd_o      <= legal_rw && (cmd == CMD_RD);
         wr_o      <= legal_rw && (cmd == CMD_WR);
         pre_o     <= (cmd == CMD_PRE);
         ref_o     <= legal_ref;
         mrs_o     <= (cmd == CMD_MRS);
         autopre_o <= legal_rw && ap_flag;
         err_o     <= bad_cmd;
         if (legal_rw) begin
            col_o      <= addr_i[COL_W-1:0];
            cmd_bank_o <= ba_i;
         end
         if (cmd == CMD_MRS) mode_o <= addr_i;
      end
   end

endmodule

// File: rtl/sdram_cmd_front_chk.sv
module sdram_cmd_front_chk #(
   parameter int ADDR_W = 12,
   parameter int BANK_W = 2,
   parameter int AP_BIT = 10
) (
   input logic                          clk_i,
   input logic                          rst_ni,
   input logic                          cke_i,
   input logic                          cs_ni,
   input logic [ADDR_W-1:0]             addr_i,
   input logic                          act_o,
   input logic                          rd_o,
   input logic                          wr_o,
   input logic                          pre_o,
   input logic                          ref_o,
   input logic                          mrs_o,
   input logic                          autopre_o,
   input logic                          err_o,
   input logic [BANK_W-1:0]             cmd_bank_o,
   input logic [(1<<BANK_W)-1:0]        bank_open_o,
   input logic [(1<<BANK_W)*ADDR_W-1:0] bank_row_o
);

   localparam int NB = 1 << BANK_W;

   AST_ONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones({act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, err_o}) <= 1); // R11

   AST_AP_NEEDS_RW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      autopre_o |-> (rd_o || wr_o)); // R4

   AST_CS_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cke_i && cs_ni) |=> !(act_o || rd_o || wr_o || pre_o || ref_o || mrs_o || err_o)); // R6

   AST_CKE_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cke_i |=> ($stable(bank_open_o) && $stable(bank_row_o) && !err_o && !act_o)); // R7

   AST_REF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ref_o |-> ($past(bank_open_o) == '0)); // R9

   AST_RW_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_o || wr_o) |-> (($past(bank_open_o) & (NB'(1) << cmd_bank_o)) != '0)); // R3

   AST_PRE_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pre_o && $past(addr_i[AP_BIT])) |-> (bank_open_o == '0)); // R5

endmodule

bind sdram_cmd_front sdram_cmd_front_chk #(
   .ADDR_W (ADDR_W),
   .BANK_W (BANK_W),
   .AP_BIT (AP_BIT)
) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .cke_i       (cke_i),
   .cs_ni       (cs_ni),
   .addr_i      (addr_i),
   .act_o       (act_o),
   .rd_o        (rd_o),
   .wr_o        (wr_o),
   .pre_o       (pre_o),
   .ref_o       (ref_o),
   .mrs_o       (mrs_o),
   .autopre_o   (autopre_o),
   .err_o       (err_o),
   .cmd_bank_o  (cmd_bank_o),
   .bank_open_o (bank_open_o),
   .bank_row_o  (bank_row_o)
);

// File: tb/sdram_cmd_front_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_front_tb_top;

   localparam logic [2:0] C_ACT = 3'b011;
   localparam logic [2:0] C_RD  = 3'b101;
   localparam logic [2:0] C_WR  = 3'b100;
   localparam logic [2:0] C_PRE = 3'b010;
   localparam logic [2:0] C_REF = 3'b001;
   localparam logic [2:0] C_MRS = 3'b000;
   localparam logic [2:0] C_NOP = 3'b111;
   localparam logic [2:0] C_BST = 3'b110;
   localparam int         BL    = 4;

   logic        clk = 1'b0;
   logic        rst_ni = 1'b0;
   logic        cke_i = 1'b1, cs_ni = 1'b1, ras_ni = 1'b1, cas_ni = 1'b1, we_ni = 1'b1;
   logic [11:0] addr_i = '0;
   logic [1:0]  ba_i = '0;
   logic act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, autopre_o, err_o;
   logic [1:0]  cmd_bank_o;
   logic [7:0]  col_o;
   logic [3:0]  bank_open_o;
   logic [47:0] bank_row_o;
   logic [11:0] mode_o;

   always #10 clk = ~clk;

   sdram_cmd_front dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .cke_i(cke_i), .cs_ni(cs_ni),
      .ras_ni(ras_ni), .cas_ni(cas_ni), .we_ni(we_ni), .addr_i(addr_i), .ba_i(ba_i),
      .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o), .ref_o(ref_o),
      .mrs_o(mrs_o), .autopre_o(autopre_o), .err_o(err_o), .cmd_bank_o(cmd_bank_o),
      .col_o(col_o), .bank_open_o(bank_open_o), .bank_row_o(bank_row_o), .mode_o(mode_o)
   );

   int          n_chk = 0, n_fail = 0;
   int          m_open [4];
   int          m_cnt  [4];
   logic [11:0] m_row  [4];
   logic [11:0] m_mode;
   logic [7:0]  m_col;
   logic [1:0]  m_bank;
   logic [7:0]  e_pulse;   // {act,rd,wr,pre,ref,mrs,autopre,err}

   task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin
         m_open[i] = 0; m_cnt[i] = 0; m_row[i] = '0;
      end
      m_mode = '0; m_col = '0; m_bank = '0; e_pulse = '0;
   endtask

   task automatic model_step(input logic cke, input logic cs, input logic [2:0] rcw,
                             input logic [11:0] a, input logic [1:0] b);
      int touched [4];
      int any_open;
      e_pulse = '0;
      if (!cke) return;
      any_open = 0;
      for (int i = 0; i < 4; i++) begin
         touched[i] = 0;
         if (m_open[i] != 0) any_open = 1;
      end
      if (!cs) begin
         case (rcw)
            C_ACT: begin
               if (m_open[b] != 0) e_pulse[0] = 1'b1;
               else begin
                  e_pulse[7] = 1'b1; m_open[b] = 1; m_row[b] = a; m_cnt[b] = 0; touched[b] = 1;
               end
            end
            C_RD, C_WR: begin
               if (m_open[b] == 0) e_pulse[0] = 1'b1;
               else begin
                  if (rcw == C_RD) e_pulse[6] = 1'b1; else e_pulse[5] = 1'b1;
                  m_col = a[7:0]; m_bank = b;
                  if (a[10]) begin
                     e_pulse[1] = 1'b1; m_cnt[b] = BL; touched[b] = 1;
                  end
               end
            end
            C_PRE: begin
               e_pulse[4] = 1'b1;
               for (int i = 0; i < 4; i++)
                  if (a[10] || i == int'(b)) begin
                     m_open[i] = 0; m_cnt[i] = 0; touched[i] = 1;
                  end
            end
            C_REF: begin
               if (any_open != 0) e_pulse[0] = 1'b1; else e_pulse[3] = 1'b1;
            end
            C_MRS: begin
               e_pulse[2] = 1'b1; m_mode = a;
            end
            default: ;
         endcase
      end
      for (int i = 0; i < 4; i++)
         if (touched[i] == 0 && m_cnt[i] > 0) begin
            m_cnt[i]--;
            if (m_cnt[i] == 0) m_open[i] = 0;
         end
   endtask

   task automatic compare(input string tag);
      logic [3:0]  eo;
      logic [47:0] er;
      for (int i = 0; i < 4; i++) begin
         eo[i] = (m_open[i] != 0);
         er[i*12 +: 12] = m_row[i];
      end
      chk(tag, "pulses", {act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, autopre_o, err_o}, e_pulse);
      chk(tag, "bank_open", bank_open_o, eo);
      chk(tag, "rows", bank_row_o, er);
      chk(tag, "col", col_o, m_col);
      chk(tag, "cmd_bank", cmd_bank_o, m_bank);
      chk(tag, "mode", mode_o, m_mode);
   endtask

   task automatic step(input logic cke, input logic cs, input logic [2:0] rcw,
                       input logic [11:0] a, input logic [1:0] b, input string tag);
      cke_i = cke; cs_ni = cs; {ras_ni, cas_ni, we_ni} = rcw; addr_i = a; ba_i = b;
      @(posedge clk);
      model_step(cke, cs, rcw, a, b);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(input int n, input string tag);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, C_NOP, 12'h000, 2'd0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_ni = 1'b1;
      compare("R1");

      // R2 activates, R3 plain read and write
      step(1, 0, C_ACT, 12'hABC, 2'd0, "R2");
      step(1, 0, C_ACT, 12'h123, 2'd2, "R2");
      step(1, 0, C_RD,  12'h05A, 2'd0, "R3");
      step(1, 0, C_WR,  12'h0C3, 2'd2, "R3");
      // R8 rule violations
      step(1, 0, C_ACT, 12'h777, 2'd0, "R8");
      step(1, 0, C_RD,  12'h011, 2'd1, "R8");
      step(1, 0, C_WR,  12'h411, 2'd3, "R8");
      // R9 refresh while banks open
      step(1, 0, C_REF, 12'h000, 2'd0, "R9");
      // R10 mode load
      step(1, 0, C_MRS, 12'h033, 2'd0, "R10");
      // R6 chip select high
      step(1, 1, C_ACT, 12'hFFF, 2'd1, "R6");
      step(1, 1, C_PRE, 12'h400, 2'd0, "R6");
      step(1, 1, C_MRS, 12'h555, 2'd0, "R6");
      // R11 no-effect codes
      step(1, 0, C_NOP, 12'h4FF, 2'd3, "R11");
      step(1, 0, C_BST, 12'h4FF, 2'd1, "R11");
      // R4 auto-precharge, R12 activate on the expiry edge
      step(1, 0, C_RD,  12'h411, 2'd0, "R4");
      idle(BL - 1, "R4");
      step(1, 0, C_ACT, 12'h999, 2'd0, "R12");
      step(1, 0, C_ACT, 12'h321, 2'd0, "R12");
      // R12 reload on the expiry edge
      step(1, 0, C_RD,  12'h4C0, 2'd2, "R4");
      idle(BL - 1, "R12");
      step(1, 0, C_WR,  12'h4C7, 2'd2, "R12");
      idle(BL, "R12");
      // R7 clock enable low freezes pending close; R6 count runs with cs high
      step(1, 0, C_ACT, 12'h0F0, 2'd1, "R7");
      step(1, 0, C_RD,  12'h402, 2'd1, "R7");
      step(0, 0, C_PRE, 12'h400, 2'd0, "R7");
      step(0, 0, C_ACT, 12'h111, 2'd3, "R7");
      step(0, 0, C_MRS, 12'h222, 2'd0, "R7");
      step(0, 1, C_NOP, 12'h000, 2'd0, "R7");
      for (int i = 0; i < BL; i++) step(1, 1, C_NOP, 12'h000, 2'd0, "R6");
      // R5 single and all-bank precharge
      step(1, 0, C_ACT, 12'hAAA, 2'd3, "R5");
      step(1, 0, C_ACT, 12'h0F1, 2'd1, "R5");
      step(1, 0, C_PRE, 12'h000, 2'd3, "R5");
      step(1, 0, C_PRE, 12'h400, 2'd1, "R5");
      // R9 legal refresh
      step(1, 0, C_REF, 12'h000, 2'd0, "R9");
      // R3 column from low bits only, R4 write with auto-precharge
      step(1, 0, C_ACT, 12'h5A5, 2'd3, "R3");
      step(1, 0, C_RD,  12'hBFF, 2'd3, "R3");
      step(1, 0, C_WR,  12'h7AB, 2'd3, "R4");
      idle(BL + 1, "R4");
      step(1, 0, C_REF, 12'h000, 2'd0, "R9");

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule